// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is a passive monitor for an asynchronous DRAM bus. It samples the four active-low control strobes (row strobe, column strobe, write enable and output enable) with a fast system clock, brings them into the clock domain through a chain of flip-flops, and finds edges on the synchronised copies. From the order of those edges it works out what kind of memory cycle the controller has just run. The kinds are a plain read, an early write, a delayed write, a read-modify-write, a row-strobe-only refresh, a column-before-row refresh, a hidden refresh tucked behind a read, and a multi-pulse page cycle. A cycle whose strobe order makes no sense is reported as an error.

Each cycle is reported once, when the row strobe goes inactive, as a single-cycle valid pulse with a one-hot type code. The monitor also models when the memory would drive its data pins, given the strobes it has seen. It raises a pulse when a write starts while output enable is still asserted, which would cause bus contention. It keeps a wrapping count of refresh cycles. The block is meant to sit beside a DRAM controller in simulation or on silicon, as a protocol observer. Timing checks finer than one sample clock are out of its scope.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `cyc_valid`, `cyc_type`, `dout_en` and `contention` are all zero and `refresh_cnt` is zero.
- R2: Each rising edge of the synchronised row strobe produces exactly one `cyc_valid` pulse, one clock long, carrying exactly one set bit in `cyc_type`. `cyc_type` is all zero when `cyc_valid` is low. The bit positions are: 0 read, 1 early write, 2 delayed write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh, 7 page, 8 error.
- R3: A row window with one column pulse, with write enable high when the column strobe falls and no later write-enable fall, is reported as read (bit 0). `dout_en` is high while output enable is low, from the column fall onward, and this includes after the column strobe rises while the row strobe stays low. `dout_en` returns to zero once both row and column strobes are high.
- R4: When write enable is low as the column strobe falls, the single-pulse cycle is an early write (bit 1), and `dout_en` stays zero even with output enable low.
- R5: When write enable falls while the column strobe is low, after a column fall with write enable high, and output enable was not low at any time during that column pulse, the cycle is a delayed write (bit 2).
- R6: When output enable was low during the column pulse before write enable falls, the cycle is a read-modify-write (bit 3).
- R7: A write-enable fall during a read column pulse inside a normal row window, with output enable low at that moment, gives a one-cycle `contention` pulse. With output enable high, no pulse is produced.
- R8: A row window with no column-strobe fall is a row-only refresh (bit 4).
- R9: A column fall in an earlier sample than the row fall, with write enable high at the row fall, is a column-before-row refresh (bit 5), and `dout_en` stays zero during it.
- R10: A read that ends with the row strobe rising while the column strobe is held low is reported as read. If the row strobe then falls again with the column strobe still low, the next report is a hidden refresh (bit 6). `dout_en` stays high through both reports while output enable is low.
- R11: Two or more column pulses within one row window are reported as a page cycle (bit 7), whatever the write enable does.
- R12: The cycle is reported as error (bit 8) in three cases: row and column strobes fall in the same sample; write enable is low when the row strobe falls with the column strobe already low; or the column strobe falls again inside a refresh window.
- R13: `refresh_cnt` goes up by exactly one, one cycle after each report of type 4, 5 or 6, and holds its value after any other report or when there is no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| row_strobe_n | input | 1 | Row address strobe, active low, asynchronous |
| col_strobe_n | input | 1 | Column address strobe, active low, asynchronous |
| wr_en_n | input | 1 | Write enable, active low, asynchronous |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| cyc_valid | output | 1 | One-cycle pulse when a cycle is classified |
| cyc_type | output | NUM_TYPES (9) | One-hot cycle type, valid with `cyc_valid` |
| dout_en | output | 1 | Memory would be driving its data pins |
| contention | output | 1 | Write began with output enable asserted |
| refresh_cnt | output | CNT_W (16) | Wrapping count of refresh cycles |

## Verification
The main stimulus is a sweep over every combination of zero, one or two column pulses per row window, write enable low or high at the column fall, a late write-enable fall or none, and an output-enable pulse before the write or none. Together these separate read, early write, delayed write, read-modify-write, row-only refresh and page cycles, and they also show where the data output is and is not enabled. Directed sequences then cover the orderings the sweep cannot reach: a column strobe leading the row strobe, a row strobe toggling under a held column strobe after a read, simultaneous falls, write enable low at a refresh entry, and a second column pulse inside a refresh. A further directed case drops write enable while output enable is still low, to check that contention is flagged. The refresh count is compared at the end against the number of refresh cycles the bench expects.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int NUM_STROBES = 4;
    localparam int SIG_ROW     = 0;
    localparam int SIG_COL     = 1;
    localparam int SIG_WR      = 2;
    localparam int SIG_OE      = 3;

    typedef enum logic [3:0] {
        CYC_READ     = 4'd0,
        CYC_EARLY_WR = 4'd1,
        CYC_DLY_WR   = 4'd2,
        CYC_RMW      = 4'd3,
        CYC_ROW_REF  = 4'd4,
        CYC_CBR_REF  = 4'd5,
        CYC_HID_REF  = 4'd6,
        CYC_PAGE     = 4'd7,
        CYC_ERROR    = 4'd8
    } cyc_e;

    localparam int NUM_TYPES = 9;

    typedef enum logic [1:0] {
        WIN_NORMAL = 2'd0,
        WIN_CBR    = 2'd1,
        WIN_HIDDEN = 2'd2,
        WIN_ERROR  = 2'd3
    } win_e;

    typedef struct packed {
        logic [1:0] col_pulses;   // saturating at 2
        logic       early_wr;
        logic       rmw;
        logic       dly_wr;
    } win_flags_t;

    function automatic cyc_e pick_type(win_e kind, win_flags_t f);
        cyc_e t;
        case (kind)
            WIN_CBR:    t = CYC_CBR_REF;
            WIN_HIDDEN: t = CYC_HID_REF;
            WIN_ERROR:  t = CYC_ERROR;
            default: begin
                if (f.col_pulses == 2'd0)      t = CYC_ROW_REF;
                else if (f.col_pulses >= 2'd2) t = CYC_PAGE;
                else if (f.early_wr)           t = CYC_EARLY_WR;
                else if (f.rmw)                t = CYC_RMW;
                else if (f.dly_wr)             t = CYC_DLY_WR;
                else                           t = CYC_READ;
            end
        endcase
        return t;
    endfunction

    function automatic logic [NUM_TYPES-1:0] to_onehot(cyc_e c);
        logic [NUM_TYPES-1:0] r;
        r = '0;
        r[c] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dcd_strobe_sync.sv
module dcd_strobe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // stage STAGES-1 is the synchronised level, stage STAGES its history
    logic [STAGES:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[STAGES-1:0], din};
    end

    assign lvl = stg[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign fall[b] =  stg[STAGES][b] & ~stg[STAGES-1][b];
        assign rise[b] = ~stg[STAGES][b] &  stg[STAGES-1][b];
    end
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
    import dcd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STROBES-1:0] lvl,
    input  logic [NUM_STROBES-1:0] rise,
    input  logic [NUM_STROBES-1:0] fall,
    output logic                   valid,
    output logic [NUM_TYPES-1:0]   type_oh,
    output logic                   cont,
    output logic                   dout_en
);
    win_e       kind_q;
    win_flags_t fl_q;
    logic       pulse_rd_q;   // current column pulse began as a read
    logic       oe_seen_q;    // output enable seen low during it
    logic       data_live_q;  // memory holds data on its pins
    logic       hid_arm_q;    // read ended with column held low

    logic row_lo, col_lo, wr_lo, oe_lo;
    assign row_lo = ~lvl[SIG_ROW];
    assign col_lo = ~lvl[SIG_COL];
    assign wr_lo  = ~lvl[SIG_WR];
    assign oe_lo  = ~lvl[SIG_OE];

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q     <= WIN_NORMAL;
            fl_q       <= '0;
            pulse_rd_q <= 1'b0;
            oe_seen_q  <= 1'b0;
            valid      <= 1'b0;
            type_oh    <= '0;
            cont       <= 1'b0;
        end else begin
            valid   <= 1'b0;
            type_oh <= '0;
            cont    <= 1'b0;
            if (fall[SIG_ROW]) begin
                fl_q       <= '0;
                pulse_rd_q <= 1'b0;
                oe_seen_q  <= 1'b0;
                if (fall[SIG_COL])  kind_q <= WIN_ERROR;
                else if (col_lo)    kind_q <= wr_lo ? WIN_ERROR
                                            : (hid_arm_q ? WIN_HIDDEN : WIN_CBR);
                else                kind_q <= WIN_NORMAL;
            end else if (row_lo) begin
                if (kind_q == WIN_NORMAL) begin
                    if (fall[SIG_COL]) begin
                        if (fl_q.col_pulses != 2'd2)
                            fl_q.col_pulses <= fl_q.col_pulses + 2'd1;
                        if (wr_lo) fl_q.early_wr <= 1'b1;
                        pulse_rd_q <= ~wr_lo;
                        oe_seen_q  <= oe_lo;
                    end else if (col_lo && pulse_rd_q) begin
                        if (fall[SIG_WR]) begin
                            if (oe_seen_q || oe_lo) fl_q.rmw    <= 1'b1;
                            else                    fl_q.dly_wr <= 1'b1;
                            cont       <= oe_lo;
                            pulse_rd_q <= 1'b0;
                        end else if (oe_lo) begin
                            oe_seen_q <= 1'b1;
                        end
                    end
                end else if (fall[SIG_COL]) begin
                    kind_q <= WIN_ERROR;
                end
            end
            if (rise[SIG_ROW]) begin
                valid   <= 1'b1;
                type_oh <= to_onehot(pick_type(kind_q, fl_q));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_live_q <= 1'b0;
            hid_arm_q   <= 1'b0;
        end else begin
            if (lvl[SIG_ROW] && lvl[SIG_COL])
                data_live_q <= 1'b0;
            else if (fall[SIG_COL] && row_lo && !fall[SIG_ROW] && kind_q == WIN_NORMAL)
                data_live_q <= ~wr_lo;

            if (rise[SIG_COL])
                hid_arm_q <= 1'b0;
            else if (rise[SIG_ROW] && col_lo && data_live_q)
                hid_arm_q <= 1'b1;
        end
    end

    assign dout_en = data_live_q & oe_lo;

    // R7: a contention report never lasts more than one cycle
    assert_cont_single_R7: assert property (@(posedge clk) disable iff (rst)
        cont |=> !cont);
endmodule

// File: rtl/dcd_refresh_counter.sv
module dcd_refresh_counter
    import dcd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic [NUM_TYPES-1:0] type_oh,
    output logic [CNT_W-1:0]     count
);
    logic is_ref;
    assign is_ref = valid & (type_oh[CYC_ROW_REF] | type_oh[CYC_CBR_REF] | type_oh[CYC_HID_REF]);

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (is_ref) count <= count + 1'b1;
    end

    assert_ref_step_R13: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> count == $past(count) + 1'b1);
    assert_ref_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !is_ref |=> $stable(count));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 row_strobe_n,
    input  logic                 col_strobe_n,
    input  logic                 wr_en_n,
    input  logic                 out_en_n,
    output logic                 cyc_valid,
    output logic [NUM_TYPES-1:0] cyc_type,
    output logic                 dout_en,
    output logic                 contention,
    output logic [CNT_W-1:0]     refresh_cnt
);
    logic [NUM_STROBES-1:0] raw, lvl, rise, fall;

    always_comb begin
        raw          = '1;
        raw[SIG_ROW] = row_strobe_n;
        raw[SIG_COL] = col_strobe_n;
        raw[SIG_WR]  = wr_en_n;
        raw[SIG_OE]  = out_en_n;
    end

    dcd_strobe_sync #(.W(NUM_STROBES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw), .lvl(lvl), .rise(rise), .fall(fall)
    );

    dcd_classifier u_cls (
        .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall),
        .valid(cyc_valid), .type_oh(cyc_type), .cont(contention), .dout_en(dout_en)
    );

    dcd_refresh_counter #(.CNT_W(CNT_W)) u_ref (
        .clk(clk), .rst(rst), .valid(cyc_valid), .type_oh(cyc_type), .count(refresh_cnt)
    );

    assert_type_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> $countones(cyc_type) == 1);
    assert_type_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> cyc_type == '0);
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> !cyc_valid);
endmodule

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
    localparam int HOLD = 6;
    localparam int NT   = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic          cyc_valid, dout_en, contention;
    logic [NT-1:0] cyc_type;
    logic [15:0]   refresh_cnt;

    always #5 clk = ~clk;

    dram_cycle_decoder dut (
        .clk(clk), .rst(rst),
        .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
        .wr_en_n(wr_en_n), .out_en_n(out_en_n),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .dout_en(dout_en),
        .contention(contention), .refresh_cnt(refresh_cnt)
    );

    int n_chk = 0, n_fail = 0;
    int vcount = 0, cont_count = 0, exp_ref = 0;
    logic [NT-1:0] last_type = '0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cyc_valid) begin
                vcount++;
                last_type = cyc_type;
            end
            if (contention) cont_count++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic c, input logic w, input logic o);
        @(negedge clk);
        row_strobe_n = r; col_strobe_n = c; wr_en_n = w; out_en_n = o;
        repeat (HOLD) @(negedge clk);
        #1;
    endtask

    task automatic expect_report(input string req, input int v0, input int idx);
        chk(vcount == v0 + 1, "R2", "report count", vcount, v0 + 1);
        chk(last_type == NT'(1) << idx, req, "cycle type", last_type, NT'(1) << idx);
    endtask

    function automatic string req_of(input int idx);
        case (idx)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic sweep();
        int v0, c0, e;
        logic wl;
        for (int n = 0; n < 3; n++)
            for (int ew = 0; ew < 2; ew++)
                for (int late = 0; late < 2; late++)
                    for (int ob = 0; ob < 2; ob++) begin
                        v0 = vcount;
                        c0 = cont_count;
                        wl = (ew != 0) ? 1'b0 : 1'b1;
                        step(0, 1, 1, 1);
                        for (int p = 0; p < n; p++) begin
                            if (ew != 0) step(0, 1, 0, 1);
                            step(0, 0, wl, 1);
                            if (ob != 0) begin
                                step(0, 0, wl, 0);
                                chk(dout_en == (ew == 0), (ew != 0) ? "R4" : "R3",
                                    "dout_en with output enable low", dout_en, ew == 0);
                                step(0, 0, wl, 1);
                            end
                            if (late != 0 && ew == 0) begin
                                step(0, 0, 0, 1);
                                step(0, 0, 1, 1);
                            end
                            step(0, 1, 1, 1);
                        end
                        step(1, 1, 1, 1);
                        if (n == 0)                    e = 4;
                        else if (n >= 2)               e = 7;
                        else if (ew != 0)              e = 1;
                        else if (late != 0 && ob != 0) e = 3;
                        else if (late != 0)            e = 2;
                        else                           e = 0;
                        if (e == 4) exp_ref++;
                        expect_report(req_of(e), v0, e);
                        chk(cont_count == c0, "R7", "no contention with output disabled",
                            cont_count, c0);
                        chk(dout_en == 1'b0, "R3", "dout_en after both strobes high", dout_en, 0);
                    end
    endtask

    initial begin
        int v0, c0;
        repeat (5) @(negedge clk);
        chk(cyc_valid == 0 && cyc_type == 0, "R1", "report idle in reset", cyc_type, 0);
        rst = 1'b0;
        #1;
        chk(cyc_valid == 0 && dout_en == 0 && contention == 0, "R1", "outputs idle after reset",
            {cyc_valid, dout_en, contention}, 0);
        chk(refresh_cnt == 0, "R1", "refresh count after reset", refresh_cnt, 0);

        sweep();

        // R3: data stays out after the column strobe rises while the row is low
        v0 = vcount;
        step(0, 1, 1, 1);
        step(0, 0, 1, 1);
        step(0, 0, 1, 0);
        chk(dout_en == 1, "R3", "dout_en during read", dout_en, 1);
        step(0, 1, 1, 0);
        chk(dout_en == 1, "R3", "dout_en held after column rise", dout_en, 1);
        step(1, 1, 1, 0);
        chk(dout_en == 0, "R3", "dout_en off after both high", dout_en, 0);
        expect_report("R3", v0, 0);
        step(1, 1, 1, 1);

        // R7: write enable falls with output enable still low
        v0 = vcount; c0 = cont_count;
        step(0, 1, 1, 1);
        step(0, 0, 1, 1);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        chk(cont_count == c0 + 1, "R7", "contention pulse", cont_count, c0 + 1);
        step(0, 0, 1, 1);
        step(0, 1, 1, 1);
        step(1, 1, 1, 1);
        expect_report("R6", v0, 3);

        // R9: column before row refresh
        v0 = vcount;
        step(1, 0, 1, 1);
        step(0, 0, 1, 1);
        step(0, 0, 1, 0);
        chk(dout_en == 0, "R9", "no data during refresh", dout_en, 0);
        step(1, 0, 1, 1);
        expect_report("R9", v0, 5);
        exp_ref++;
        step(1, 1, 1, 1);

        // R10: hidden refresh behind a read
        v0 = vcount;
        step(0, 1, 1, 1);
        step(0, 0, 1, 1);
        step(0, 0, 1, 0);
        step(1, 0, 1, 0);
        expect_report("R10", v0, 0);
        chk(dout_en == 1, "R10", "data held as row rises", dout_en, 1);
        step(0, 0, 1, 0);
        chk(dout_en == 1, "R10", "data held in hidden refresh", dout_en, 1);
        step(1, 0, 1, 0);
        expect_report("R10", v0 + 1, 6);
        exp_ref++;
        step(1, 1, 1, 0);
        chk(dout_en == 0, "R3", "data off after hidden refresh", dout_en, 0);
        step(1, 1, 1, 1);

        // R12: simultaneous falls
        v0 = vcount;
        step(0, 0, 1, 1);
        step(1, 0, 1, 1);
        expect_report("R12", v0, 8);
        step(1, 1, 1, 1);

        // R12: write enable low at refresh entry
        v0 = vcount;
        step(1, 1, 0, 1);
        step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        step(1, 0, 0, 1);
        expect_report("R12", v0, 8);
        step(1, 1, 1, 1);

        // R12: second column fall inside a refresh window
        v0 = vcount;
        step(1, 0, 1, 1);
        step(0, 0, 1, 1);
        step(0, 1, 1, 1);
        step(0, 0, 1, 1);
        step(1, 0, 1, 1);
        expect_report("R12", v0, 8);
        step(1, 1, 1, 1);

        chk(refresh_cnt == 16'(exp_ref), "R13", "refresh count", refresh_cnt, exp_ref);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule